// File: doc/BRIEF.md
# SDRAM Periodic Auto-Refresh Scheduler

This block keeps an SDRAM's contents alive by issuing auto-refresh commands on a fixed period. A down-counter is reloaded from a programmable interval value, counted in bus clocks. Each time the counter runs out, one refresh is owed. An owed refresh waits until the access sequencer reports that its current access or burst has finished. The scheduler then raises a stall that blocks every new access. If any row is open, it first closes all banks with a precharge-all command and waits the precharge time. It then issues one AUTO REFRESH command; the memory advances its own internal row address. It holds the stall until the refresh-to-activate time has elapsed.

When the sequence ends, the block pulses a signal that tells the access sequencer to forget every open-row record. Further expiries that arrive while a refresh is still owed are kept in a small saturating backlog counter, so none is lost. Writing the interval restarts the period at once. An interval of zero stops new refreshes from being owed.

Top module: `sdr_refresh_sched`

## Requirements
- R1: After reset, `stall`, `cmd_pre_all`, `cmd_refresh` and `rows_invalidate` are low, `owed` is 0 and refresh is disabled (interval 0).
- R2: With interval N ≠ 0 loaded at a clock where `intv_load` is high, `owed` rises on the clock N+1 cycles later. Expiries then repeat every N cycles, so refresh commands on an idle, closed-row bus are exactly N cycles apart.
- R3: Loading the interval restarts the countdown at once. The partly elapsed period is discarded, so with all rows closed the next refresh command appears N+2 cycles after the load cycle.
- R4: While the interval is 0, no expiry occurs and `owed` never increases.
- R5: `stall` is high whenever `owed` ≠ 0 or a refresh sequence is in progress. A sequence starts only in a cycle where `access_busy` is low, and no command is issued while it waits.
- R6: When `rows_open` is high in the start cycle, `cmd_pre_all` (precharge with the all-banks address bit set) is pulsed one cycle after the start cycle. `cmd_refresh` follows exactly max(`trp_cfg`,1) cycles after `cmd_pre_all`.
- R7: When `rows_open` is low in the start cycle, `cmd_refresh` is pulsed one cycle after the start cycle with no precharge. Each sequence issues exactly one refresh pulse.
- R8: `rows_invalidate` pulses for one cycle exactly max(`trc_cfg`,1) cycles after `cmd_refresh`. In that cycle the sequence is over, and `stall` is low unless `owed` ≠ 0.
- R9: Each expiry adds one to `owed` and each started sequence removes one. An expiry and a start in the same cycle cancel. `owed` saturates at 2^PEND_W−1 (7 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intv_load | input | 1 | Load strobe for the refresh interval |
| intv_value | input | CNT_W (16) | Interval in clocks; 0 disables refresh |
| trp_cfg | input | TIM_W (4) | Precharge-to-refresh time in clocks (0 treated as 1) |
| trc_cfg | input | TIM_W (4) | Refresh-to-activate time in clocks (0 treated as 1) |
| access_busy | input | 1 | Access sequencer is in the middle of an access or burst |
| rows_open | input | 1 | At least one bank has an open row |
| stall | output | 1 | Blocks new accesses from the sequencer |
| cmd_pre_all | output | 1 | One-cycle precharge-all-banks command |
| cmd_refresh | output | 1 | One-cycle auto-refresh command |
| rows_invalidate | output | 1 | One-cycle pulse: all open-row records are stale |
| owed | output | PEND_W (3) | Number of expired refreshes not yet started |

## Verification
A countdown that is off by one drifts the refresh spacing at once. The second refresh command lands a cycle early or late, within one interval of the load. A backlog that miscounts shows on `owed` on the clock after the expiry or start that it mishandles. A wrap instead of saturation shows within one interval once the count is full. A sequencer stuck or mis-timed in its precharge or refresh wait moves `cmd_refresh` or `rows_invalidate` away from the programmed gap in the same sequence, and it also keeps `stall` high past the expected release cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    RS_IDLE  = 3'd0,
    RS_PRE   = 3'd1,
    RS_PWAIT = 3'd2,
    RS_REF   = 3'd3,
    RS_RWAIT = 3'd4
  } rs_state_e;

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intv_load,
  input  logic [CNT_W-1:0] intv_value,
  output logic             tick
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] intv_q, intv_n;
  logic [CNT_W-1:0] tmr_q, tmr_n;
  logic             run;

  assign run  = (intv_q != '0);
  assign tick = run && (tmr_q <= ONE) && !intv_load;

  always_comb begin
    intv_n = intv_q;
    tmr_n  = tmr_q;
    if (intv_load) begin
      intv_n = intv_value;
      tmr_n  = intv_value;
    end else if (run) begin
      if (tmr_q <= ONE) tmr_n = intv_q;
      else              tmr_n = tmr_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intv_q <= '0;
      tmr_q  <= '0;
    end else begin
      intv_q <= intv_n;
      tmr_q  <= tmr_n;
    end
  end

endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              take,
  output logic [PEND_W-1:0] owed
);

  localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};
  localparam logic [PEND_W-1:0] ONE  = PEND_W'(1);

  logic [PEND_W-1:0] cnt_q, cnt_n;
  logic              upd;

  always_comb begin
    cnt_n = cnt_q;
    unique case ({tick, take})
      2'b10:   cnt_n = (cnt_q == FULL) ? cnt_q : cnt_q + ONE;
      2'b01:   cnt_n = cnt_q - ONE;
      default: cnt_n = cnt_q;
    endcase
  end

  assign upd = tick ^ take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_n;
  end

  assign owed = cnt_q;

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
  import refsched_pkg::*;
#(
  parameter int TIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             owed_nz,
  input  logic             access_busy,
  input  logic             rows_open,
  input  logic [TIM_W-1:0] trp_cfg,
  input  logic [TIM_W-1:0] trc_cfg,
  output logic             take,
  output logic             active,
  output logic             cmd_pre_all,
  output logic             cmd_refresh,
  output logic             done
);

  localparam logic [TIM_W-1:0] ONE = TIM_W'(1);
  localparam logic [TIM_W-1:0] TWO = TIM_W'(2);

  rs_state_e        st_q, st_n;
  logic [TIM_W-1:0] wait_q, wait_n;
  logic             done_q, done_n;

  always_comb begin
    st_n   = st_q;
    wait_n = wait_q;
    take   = 1'b0;
    done_n = 1'b0;
    unique case (st_q)
      RS_IDLE: begin
        if (owed_nz && !access_busy) begin
          take = 1'b1;
          st_n = rows_open ? RS_PRE : RS_REF;
        end
      end
      RS_PRE: begin
        if (trp_cfg <= ONE) st_n = RS_REF;
        else begin
          st_n   = RS_PWAIT;
          wait_n = trp_cfg - TWO;
        end
      end
      RS_PWAIT: begin
        if (wait_q == '0) st_n = RS_REF;
        else              wait_n = wait_q - ONE;
      end
      RS_REF: begin
        if (trc_cfg <= ONE) begin
          st_n   = RS_IDLE;
          done_n = 1'b1;
        end else begin
          st_n   = RS_RWAIT;
          wait_n = trc_cfg - TWO;
        end
      end
      RS_RWAIT: begin
        if (wait_q == '0) begin
          st_n   = RS_IDLE;
          done_n = 1'b1;
        end else begin
          wait_n = wait_q - ONE;
        end
      end
      default: st_n = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      wait_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      wait_q <= wait_n;
      done_q <= done_n;
    end
  end

  assign active      = (st_q != RS_IDLE);
  assign cmd_pre_all = (st_q == RS_PRE);
  assign cmd_refresh = (st_q == RS_REF);
  assign done        = done_q;

endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched #(
  parameter int CNT_W  = 16,
  parameter int TIM_W  = 4,
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              intv_load,
  input  logic [CNT_W-1:0]  intv_value,
  input  logic [TIM_W-1:0]  trp_cfg,
  input  logic [TIM_W-1:0]  trc_cfg,
  input  logic              access_busy,
  input  logic              rows_open,
  output logic              stall,
  output logic              cmd_pre_all,
  output logic              cmd_refresh,
  output logic              rows_invalidate,
  output logic [PEND_W-1:0] owed
);

  logic tick;
  logic take;
  logic seq_active;

  refsched_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .intv_load  (intv_load),
    .intv_value (intv_value),
    .tick       (tick)
  );

  refsched_backlog #(.PEND_W(PEND_W)) u_backlog (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .take  (take),
    .owed  (owed)
  );

  refsched_seq #(.TIM_W(TIM_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .owed_nz     (owed != '0),
    .access_busy (access_busy),
    .rows_open   (rows_open),
    .trp_cfg     (trp_cfg),
    .trc_cfg     (trc_cfg),
    .take        (take),
    .active      (seq_active),
    .cmd_pre_all (cmd_pre_all),
    .cmd_refresh (cmd_refresh),
    .done        (rows_invalidate)
  );

  assign stall = (owed != '0) || seq_active;

endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
  parameter int TIM_W  = 4,
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TIM_W-1:0]  trp_cfg,
  input logic [TIM_W-1:0]  trc_cfg,
  input logic              access_busy,
  input logic              rows_open,
  input logic              stall,
  input logic              cmd_pre_all,
  input logic              cmd_refresh,
  input logic              rows_invalidate,
  input logic [PEND_W-1:0] owed
);

  logic [7:0] since_pre, since_ref;
  logic       pre_armed;
  logic [7:0] trp_eff, trc_eff;

  assign trp_eff = (trp_cfg == '0) ? 8'd1 : 8'(trp_cfg);
  assign trc_eff = (trc_cfg == '0) ? 8'd1 : 8'(trc_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre <= '0;
      since_ref <= '0;
      pre_armed <= 1'b0;
    end else begin
      since_pre <= cmd_pre_all ? 8'd1 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
      since_ref <= cmd_refresh ? 8'd1 : ((since_ref == 8'hFF) ? since_ref : since_ref + 8'd1);
      if (cmd_pre_all)      pre_armed <= 1'b1;
      else if (cmd_refresh) pre_armed <= 1'b0;
    end
  end

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_pre_all && cmd_refresh)); // R6

  AST_PRE_AFTER_FREE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_all |-> $past(!access_busy && rows_open)); // R5

  AST_CMD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre_all || cmd_refresh) |-> stall); // R5

  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_refresh |=> !cmd_refresh); // R7

  AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_refresh && pre_armed) |-> (since_pre >= trp_eff)); // R6

  AST_TRC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rows_invalidate |-> (since_ref >= trc_eff)); // R8

  AST_OWED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == $past(owed)) || (owed == $past(owed) + 1'b1) || (owed == $past(owed) - 1'b1)); // R9

endmodule

bind sdr_refresh_sched refsched_checker #(.TIM_W(TIM_W), .PEND_W(PEND_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .trp_cfg         (trp_cfg),
  .trc_cfg         (trc_cfg),
  .access_busy     (access_busy),
  .rows_open       (rows_open),
  .stall           (stall),
  .cmd_pre_all     (cmd_pre_all),
  .cmd_refresh     (cmd_refresh),
  .rows_invalidate (rows_invalidate),
  .owed            (owed)
);

// File: tb/sdr_refresh_sched_test.sv
module sdr_refresh_sched_test;

  localparam int CNT_W    = 16;
  localparam int TIM_W    = 4;
  localparam int PEND_W   = 3;
  localparam int OWED_MAX = (1 << PEND_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              intv_load;
  logic [CNT_W-1:0]  intv_value;
  logic [TIM_W-1:0]  trp_cfg, trc_cfg;
  logic              access_busy, rows_open;
  logic              stall, cmd_pre_all, cmd_refresh, rows_invalidate;
  logic [PEND_W-1:0] owed;

  always #10 clk = ~clk;

  sdr_refresh_sched uut (
    .clk(clk), .rst_n(rst_n), .intv_load(intv_load), .intv_value(intv_value),
    .trp_cfg(trp_cfg), .trc_cfg(trc_cfg), .access_busy(access_busy),
    .rows_open(rows_open), .stall(stall), .cmd_pre_all(cmd_pre_all),
    .cmd_refresh(cmd_refresh), .rows_invalidate(rows_invalidate), .owed(owed)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // Reference model: absolute cycle bookkeeping of when each event is due.
  int m_cyc, m_ivl, m_due, m_owed, pre_c, ref_c, end_c;
  int pre_hist[$], ref_hist[$], inv_hist[$];
  int last_load;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_ivl = 0; m_due = -1; m_owed = 0;
      pre_c = -1; ref_c = -1; end_c = -1;
    end else begin
      int c;
      bit tk, go;
      c  = m_cyc;
      tk = (m_ivl != 0) && (c == m_due) && !intv_load;
      go = (c >= end_c) && (m_owed != 0) && !access_busy;
      if (intv_load) begin
        m_ivl = int'(intv_value);
        m_due = (m_ivl != 0) ? c + m_ivl : -1;
      end else if (tk) begin
        m_due = c + m_ivl;
      end
      if (tk && !go && m_owed < OWED_MAX) m_owed++;
      else if (go && !tk)                 m_owed--;
      if (go) begin
        if (rows_open) begin
          pre_c = c + 1;
          ref_c = pre_c + ((trp_cfg == 0) ? 1 : int'(trp_cfg));
        end else begin
          pre_c = -1;
          ref_c = c + 1;
        end
        end_c = ref_c + ((trc_cfg == 0) ? 1 : int'(trc_cfg));
      end
      m_cyc = c + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk_eq("R5", "stall", int'(stall), int'((m_cyc < end_c) || (m_owed != 0)));
      chk_eq("R6", "cmd_pre_all", int'(cmd_pre_all), int'(m_cyc == pre_c));
      chk_eq("R7", "cmd_refresh", int'(cmd_refresh), int'(m_cyc == ref_c));
      chk_eq("R8", "rows_invalidate", int'(rows_invalidate), int'(m_cyc == end_c));
      chk_eq("R9", "owed", int'(owed), m_owed);
      if (cmd_pre_all)     pre_hist.push_back(m_cyc);
      if (cmd_refresh)     ref_hist.push_back(m_cyc);
      if (rows_invalidate) inv_hist.push_back(m_cyc);
    end
  end

  task automatic load(input int v);
    @(negedge clk);
    intv_load = 1'b1;
    intv_value = CNT_W'(v);
    last_load = m_cyc;
    @(negedge clk);
    intv_load = 1'b0;
  endtask

  task automatic clear_hist();
    pre_hist.delete(); ref_hist.delete(); inv_hist.delete();
  endtask

  task automatic summary();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    intv_load = 0; intv_value = '0; trp_cfg = 4'd2; trc_cfg = 4'd7;
    access_busy = 0; rows_open = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_eq("R1", "stall after reset", int'(stall), 0);
    chk_eq("R1", "cmd_pre_all after reset", int'(cmd_pre_all), 0);
    chk_eq("R1", "cmd_refresh after reset", int'(cmd_refresh), 0);
    chk_eq("R1", "owed after reset", int'(owed), 0);
    repeat (20) @(negedge clk);
    chk_eq("R1", "no refresh while disabled", ref_hist.size(), 0);

    // R2 period with closed rows
    clear_hist();
    load(40);
    repeat (130) @(negedge clk);
    chk_eq("R2", "refresh count", ref_hist.size(), 3);
    chk_eq("R2", "first refresh cycle", (ref_hist.size() > 0) ? ref_hist[0] : -1, last_load + 42);
    chk_eq("R2", "refresh spacing", (ref_hist.size() > 1) ? ref_hist[1] - ref_hist[0] : -1, 40);
    chk_eq("R7", "no precharge with closed rows", pre_hist.size(), 0);

    // R6 / R8 precharge path
    rows_open = 1; trp_cfg = 4'd3; trc_cfg = 4'd7;
    clear_hist();
    repeat (100) @(negedge clk);
    chk(pre_hist.size() > 0 && ref_hist.size() > 0, "R6", "precharge seen", pre_hist.size(), 1);
    chk_eq("R6", "precharge to refresh gap",
           (pre_hist.size() > 0 && ref_hist.size() > 0) ? ref_hist[0] - pre_hist[0] : -1, 3);
    chk_eq("R8", "refresh to invalidate gap",
           (inv_hist.size() > 0 && ref_hist.size() > 0) ? inv_hist[0] - ref_hist[0] : -1, 7);

    // R5 hold while busy
    while (stall) @(negedge clk);
    access_busy = 1;
    clear_hist();
    repeat (90) @(negedge clk);
    chk_eq("R5", "no command while busy", pre_hist.size() + ref_hist.size(), 0);
    chk_eq("R5", "stall while owed", int'(stall), 1);

    // R9 saturation, then R4 disable and drain
    load(5);
    repeat (60) @(negedge clk);
    chk_eq("R9", "owed saturates", int'(owed), OWED_MAX);
    load(0);
    access_busy = 0;
    repeat (130) @(negedge clk);
    chk_eq("R9", "backlog drained", int'(owed), 0);
    chk_eq("R9", "one refresh per owed entry", ref_hist.size(), OWED_MAX);
    clear_hist();
    repeat (100) @(negedge clk);
    chk_eq("R4", "no refresh with zero interval", ref_hist.size(), 0);
    chk_eq("R4", "owed stays zero", int'(owed), 0);

    // R3 reload restarts period
    rows_open = 0;
    load(30);
    repeat (10) @(negedge clk);
    clear_hist();
    load(30);
    repeat (40) @(negedge clk);
    chk_eq("R3", "refresh count after reload", ref_hist.size(), 1);
    chk_eq("R3", "refresh cycle after reload", (ref_hist.size() > 0) ? ref_hist[0] : -1, last_load + 32);

    // zero timing values treated as one
    load(0);
    while (stall) @(negedge clk);
    trp_cfg = 4'd0; trc_cfg = 4'd0; rows_open = 1;
    clear_hist();
    load(12);
    repeat (40) @(negedge clk);
    chk_eq("R6", "zero trp gap", (pre_hist.size() > 0 && ref_hist.size() > 0) ? ref_hist[0] - pre_hist[0] : -1, 1);
    chk_eq("R8", "zero trc gap", (inv_hist.size() > 0 && ref_hist.size() > 0) ? inv_hist[0] - ref_hist[0] : -1, 1);
    load(0);
    repeat (20) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

endmodule